// File: doc/BRIEF.md
# PRG Bank Address Generator with Outer/Inner Merge

This block is the combinational address logic of a multi-game cartridge bank controller. It takes a 6-bit mode value, a 6-bit outer bank, a 4-bit inner bank and CPU address line A14. From these it produces the seven PRG ROM address lines A20 to A14, which address up to 2 MiB in 16 KiB units. It also drives the active-low ROM chip enable from the decoded ROM-window select.

The outer bank picks a region of ROM. The size code in the mode value sets how large that region is: 32, 64, 128 or 256 KiB. A bigger region hands more low bank bits to the inner bank and leaves fewer to the outer bank. The PRG mode in the mode value sets how the 32 KiB CPU window is served, and there are three choices:

- **Wide switching:** one switchable 32 KiB bank fills the whole window.
- **Fixed low half:** $8000-$BFFF is fixed and the upper half is a switchable 16 KiB bank.
- **Fixed high half:** $C000-$FFFF is fixed and the lower half is a switchable 16 KiB bank.

A fixed half always takes the outer bank unchanged, as if the size code were zero.

The bank controller registers feed this block directly. The block holds no state, so a change on any input shows up on the address lines in the same cycle.

Top module: `prg_bank_gen`

## Requirements
- R1: The mode value `mode_reg[5:0]` is split into fields as follows. Bits [5:4] are the size code `sz`, where 0/1/2/3 means an outer region of 32/64/128/256 KiB. Bits [3:2] are the PRG mode, where 0 and 1 mean wide switching, 2 means fixed low half and 3 means fixed high half.
- R2: In wide switching, `prg_bank[6:1]` equals `outer_bank` with its low `sz` bits replaced by the low `sz` bits of `inner_bank`, and `prg_bank[0]` equals `cpu_a14`.
- R3: In fixed low half mode with `cpu_a14`=0, `prg_bank` equals {`outer_bank`, 0}.
- R4: In fixed high half mode with `cpu_a14`=1, `prg_bank` equals {`outer_bank`, 1}.
- R5: In the switchable half of a fixed-half mode, the low `sz`+1 bits of `prg_bank` come from `inner_bank`. The remaining higher bits come from `outer_bank` shifted left by one.
- R6: In every mode, `prg_bank` shifted right by `sz`+1 equals `outer_bank` shifted right by `sz`. The outer bits above the inner-controlled field always pass through unchanged.
- R7: `rom_ce_n` equals `rom_sel_n` at all times.
- R8: Bits [1:0] of `mode_reg` are mirroring bits and have no effect on `prg_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_reg | input | 6 | Mode value: size code, PRG mode, and mirroring bits (unused here) |
| outer_bank | input | 6 | Outer bank register value |
| inner_bank | input | 4 | Inner bank register value |
| cpu_a14 | input | 1 | CPU address line A14, which selects the window half |
| rom_sel_n | input | 1 | Decoded active-low CPU access to $8000-$FFFF |
| prg_bank | output | 7 | PRG ROM address lines A20-A14 |
| rom_ce_n | output | 1 | PRG ROM chip enable, active low |

## Verification
The block is purely combinational, so any wrong merge, mask or half choice shows up on `prg_bank` immediately, with no delay. The error appears only for the input combinations that reach the faulty path. A mask that is off by one appears only at some size codes, and a swapped fixed half appears only for one value of `cpu_a14`. For this reason the bench runs every mode value against every outer bank, every inner bank and both halves, and compares each result with an independent arithmetic model.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
    localparam int OUTER_W = 6;
    localparam int INNER_W = 4;
    localparam int SIZE_W  = 2;
    localparam int BANK_W  = OUTER_W + 1;

    typedef enum logic [1:0] {
        PM_WIDE_A  = 2'd0,
        PM_WIDE_B  = 2'd1,
        PM_FIX_LO  = 2'd2,
        PM_FIX_HI  = 2'd3
    } prg_mode_e;
endpackage

// File: rtl/prg_bank_merge.sv
// Builds a bank number from an outer base, shifted left by SHIFT, whose low
// (size_code + SHIFT) bits are taken from the inner bank (capped at INNER_W).
module prg_bank_merge #(
    parameter int OUTER_W = 6,
    parameter int INNER_W = 4,
    parameter int SIZE_W  = 2,
    parameter int SHIFT   = 0
) (
    input  logic [SIZE_W-1:0]          size_code,
    input  logic [OUTER_W-1:0]         outer_bank,
    input  logic [INNER_W-1:0]         inner_bank,
    output logic [OUTER_W+SHIFT-1:0]   bank
);
    localparam int W = OUTER_W + SHIFT;

    logic [W-1:0] base;
    int           inner_bits;

    assign base       = W'(outer_bank) << SHIFT;
    assign inner_bits = int'(size_code) + SHIFT;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < INNER_W) begin : g_mix
            assign bank[i] = (inner_bits > i) ? inner_bank[i] : base[i];
        end else begin : g_pass
            assign bank[i] = base[i];
        end
    end
endmodule

// File: rtl/prg_half_select.sv
// Chooses the bank for the current window half according to the PRG mode.
module prg_half_select
    import prg_bank_pkg::*;
#(
    parameter int OUTER_W = 6
) (
    input  prg_mode_e            pmode,
    input  logic                 cpu_a14,
    input  logic [OUTER_W-1:0]   outer_bank,
    input  logic [OUTER_W-1:0]   wide_bank,
    input  logic [OUTER_W:0]     half_bank,
    output logic [OUTER_W:0]     prg_bank
);
    always_comb begin
        unique case (pmode)
            PM_WIDE_A, PM_WIDE_B: prg_bank = {wide_bank, cpu_a14};
            PM_FIX_LO: prg_bank = cpu_a14 ? half_bank : {outer_bank, 1'b0};
            PM_FIX_HI: prg_bank = cpu_a14 ? {outer_bank, 1'b1} : half_bank;
            default:   prg_bank = {wide_bank, cpu_a14};
        endcase
    end
endmodule

// File: rtl/prg_bank_gen.sv
module prg_bank_gen
    import prg_bank_pkg::*;
(
    input  logic [5:0]          mode_reg,
    input  logic [OUTER_W-1:0]  outer_bank,
    input  logic [INNER_W-1:0]  inner_bank,
    input  logic                cpu_a14,
    input  logic                rom_sel_n,
    output logic [BANK_W-1:0]   prg_bank,
    output logic                rom_ce_n
);
    logic [SIZE_W-1:0]  size_code;
    prg_mode_e          pmode;
    logic [OUTER_W-1:0] wide_bank;
    logic [OUTER_W:0]   half_bank;

    // R1: field positions in the mode value
    assign size_code = mode_reg[5:4];
    assign pmode     = prg_mode_e'(mode_reg[3:2]);

    prg_bank_merge #(
        .OUTER_W(OUTER_W), .INNER_W(INNER_W), .SIZE_W(SIZE_W), .SHIFT(0)
    ) i_wide (
        .size_code (size_code),
        .outer_bank(outer_bank),
        .inner_bank(inner_bank),
        .bank      (wide_bank)
    );

    prg_bank_merge #(
        .OUTER_W(OUTER_W), .INNER_W(INNER_W), .SIZE_W(SIZE_W), .SHIFT(1)
    ) i_half (
        .size_code (size_code),
        .outer_bank(outer_bank),
        .inner_bank(inner_bank),
        .bank      (half_bank)
    );

    prg_half_select #(.OUTER_W(OUTER_W)) i_sel (
        .pmode     (pmode),
        .cpu_a14   (cpu_a14),
        .outer_bank(outer_bank),
        .wide_bank (wide_bank),
        .half_bank (half_bank),
        .prg_bank  (prg_bank)
    );

    // R7: chip enable follows the decoded window select
    assign rom_ce_n = rom_sel_n;
endmodule

// File: rtl/prg_bank_gen_chk.sv
module prg_bank_gen_chk (
    input logic [5:0] mode_reg,
    input logic [5:0] outer_bank,
    input logic [3:0] inner_bank,
    input logic       cpu_a14,
    input logic       rom_sel_n,
    input logic [6:0] prg_bank,
    input logic       rom_ce_n
);
    int sz;
    assign sz = int'(mode_reg[5:4]);

    always_comb begin
        // R2
        wide_a14_chk: assert (mode_reg[3] || prg_bank[0] == cpu_a14);
        // R3
        fix_lo_chk: assert (!(mode_reg[3:2] == 2'd2 && !cpu_a14)
                            || prg_bank == {outer_bank, 1'b0});
        // R4
        fix_hi_chk: assert (!(mode_reg[3:2] == 2'd3 && cpu_a14)
                            || prg_bank == {outer_bank, 1'b1});
        // R5
        half_lsb_chk: assert (!(mode_reg[3] && (mode_reg[2] != cpu_a14))
                              || prg_bank[0] == inner_bank[0]);
        // R6
        upper_pass_chk: assert ((7'(prg_bank) >> (sz + 1)) == (7'(outer_bank) >> sz));
        // R7
        ce_idle_chk: assert (!rom_sel_n || rom_ce_n);
    end
endmodule

bind prg_bank_gen prg_bank_gen_chk i_chk (
    .mode_reg  (mode_reg),
    .outer_bank(outer_bank),
    .inner_bank(inner_bank),
    .cpu_a14   (cpu_a14),
    .rom_sel_n (rom_sel_n),
    .prg_bank  (prg_bank),
    .rom_ce_n  (rom_ce_n)
);

// File: tb/test_prg_bank_gen.sv
module test_prg_bank_gen;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 24;
    localparam int WATCHDOG = 190000;

    logic       clk = 1'b0;
    logic [5:0] mode_reg = '0;
    logic [5:0] outer_bank = '0;
    logic [3:0] inner_bank = '0;
    logic       cpu_a14 = 1'b0;
    logic       rom_sel_n = 1'b1;
    logic [6:0] prg_bank;
    logic       rom_ce_n;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prg_bank_gen i_prg_bank_gen (
        .mode_reg(mode_reg), .outer_bank(outer_bank), .inner_bank(inner_bank),
        .cpu_a14(cpu_a14), .rom_sel_n(rom_sel_n),
        .prg_bank(prg_bank), .rom_ce_n(rom_ce_n)
    );

    // {mode, outer, inner, a14, expected bank}; outer $12, inner $07
    typedef struct packed {
        logic [5:0] m; logic [5:0] o; logic [3:0] i; logic a; logic [6:0] e;
    } vec_t;
    localparam vec_t VEC [N_VEC] = '{
        '{6'h00, 6'h12, 4'h7, 1'b0, 7'h24}, '{6'h00, 6'h12, 4'h7, 1'b1, 7'h25},
        '{6'h10, 6'h12, 4'h7, 1'b0, 7'h26}, '{6'h10, 6'h12, 4'h7, 1'b1, 7'h27},
        '{6'h20, 6'h12, 4'h7, 1'b1, 7'h27}, '{6'h30, 6'h12, 4'h7, 1'b0, 7'h2E},
        '{6'h30, 6'h12, 4'h7, 1'b1, 7'h2F}, '{6'h08, 6'h12, 4'h7, 1'b0, 7'h24},
        '{6'h08, 6'h12, 4'h7, 1'b1, 7'h25}, '{6'h0C, 6'h12, 4'h7, 1'b0, 7'h25},
        '{6'h0C, 6'h12, 4'h7, 1'b1, 7'h25}, '{6'h18, 6'h12, 4'h7, 1'b0, 7'h24},
        '{6'h18, 6'h12, 4'h7, 1'b1, 7'h27}, '{6'h1C, 6'h12, 4'h7, 1'b0, 7'h27},
        '{6'h1C, 6'h12, 4'h7, 1'b1, 7'h25}, '{6'h28, 6'h12, 4'h7, 1'b1, 7'h27},
        '{6'h2C, 6'h12, 4'h7, 1'b0, 7'h27}, '{6'h38, 6'h12, 4'h7, 1'b0, 7'h24},
        '{6'h38, 6'h12, 4'h7, 1'b1, 7'h27}, '{6'h3C, 6'h12, 4'h7, 1'b0, 7'h27},
        '{6'h3C, 6'h12, 4'h7, 1'b1, 7'h25}, '{6'h3B, 6'h12, 4'h7, 1'b1, 7'h27},
        '{6'h13, 6'h12, 4'h7, 1'b0, 7'h26}, '{6'h06, 6'h12, 4'h7, 1'b1, 7'h25}
    };

    function automatic logic [6:0] model(input logic [5:0] m, input logic [5:0] o,
                                         input logic [3:0] i, input logic a);
        int sz  = int'(m[5:4]);
        int pm  = int'(m[3:2]);
        int w32 = ((int'(o) >> sz) << sz) | (int'(i) & ((1 << sz) - 1));
        int h16 = (((int'(o) * 2) >> (sz + 1)) << (sz + 1)) | (int'(i) & ((2 << sz) - 1));
        int r;
        if (pm < 2)             r = w32 * 2 + int'(a);
        else if (pm == 2)       r = a ? h16 : int'(o) * 2;
        else                    r = a ? int'(o) * 2 + 1 : h16;
        return 7'(r);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (mode %0h outer %0h inner %0h a14 %0b)",
                     req, act, exp, mode_reg, outer_bank, inner_bank, cpu_a14);
        end
    endtask

    task automatic apply(input logic [5:0] m, input logic [5:0] o,
                         input logic [3:0] i, input logic a);
        @(negedge clk);
        mode_reg = m; outer_bank = o; inner_bank = i; cpu_a14 = a;
        #1;
    endtask

    function automatic string req_of(input logic [5:0] m, input logic a);
        if (m[3:2] == 2'd2 && !a) return "R3";
        if (m[3:2] == 2'd3 && a)  return "R4";
        if (m[3])                 return "R5";
        return "R2";
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // idle state: all zero inputs, select inactive (R7, R2)
        apply(6'h00, 6'h00, 4'h0, 1'b0);
        check("R7 idle ce", int'(rom_ce_n), 1);
        check("R2 idle bank", int'(prg_bank), 0);

        // R1 R2 R3 R4 R5 R8: table walk
        for (int k = 0; k < N_VEC; k++) begin
            apply(VEC[k].m, VEC[k].o, VEC[k].i, VEC[k].a);
            check(k >= 21 ? "R8 table" : "R1 table", int'(prg_bank), int'(VEC[k].e));
        end

        // R7: chip enable follows select both ways
        rom_sel_n = 1'b0; #1;
        check("R7 select low", int'(rom_ce_n), 0);
        rom_sel_n = 1'b1; #1;
        check("R7 select high", int'(rom_ce_n), 1);

        // R8: mirroring bits do not alter the bank
        for (int mm = 0; mm < 4; mm++) begin
            apply(6'h2C | 6'(mm), 6'h2A, 4'h9, 1'b0);
            check("R8 mirror", int'(prg_bank), int'(model(6'h2C, 6'h2A, 4'h9, 1'b0)));
        end

        // R6: size 3 caps inner use at bit 3
        apply(6'h3C, 6'h3F, 4'hF, 1'b0);
        check("R6 size3 cap", int'(prg_bank), 7'h7F);
        apply(6'h38, 6'h20, 4'hF, 1'b1);
        check("R6 size3 upper", int'(prg_bank), 7'h4F);

        // exhaustive sweep against the model
        for (int m = 0; m < 64; m += 1) begin
            for (int o = 0; o < 64; o++) begin
                for (int i = 0; i < 16; i++) begin
                    for (int a = 0; a < 2; a++) begin
                        mode_reg = 6'(m); outer_bank = 6'(o);
                        inner_bank = 4'(i); cpu_a14 = a[0];
                        #1;
                        check(req_of(6'(m), a[0]), int'(prg_bank),
                              int'(model(6'(m), 6'(o), 4'(i), a[0])));
                    end
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule